// File: doc/BRIEF.md
# Branch Resolver with Link and Count Registers

This block settles the outcome of one branch per cycle. It is given the address of the branch, the decoded branch fields and the current condition register. It then decides whether the branch is taken and which address fetch should use next. The block holds two 32-bit architected registers. The link register captures return addresses. The count register serves as a loop counter, and it can be decremented as part of the branch test. Either register can also supply a full 32-bit jump target, which reaches addresses that a displacement cannot.

The condition options are independent of one another. One option says whether a chosen condition bit must be set, must be clear, or is not looked at. A second option says whether the count register is decremented and, if so, whether the decremented value must be non-zero, must be zero, or is not tested. The branch is taken only when both tests pass. A separate register write port loads either register, as a move-to-register instruction would.

The outcome appears one clock after the branch is presented. The link and count registers update on the same edge.

Top module: `brx_resolver`

## Requirements
- R1: While reset is asserted, and until the first branch, the result-valid output is 0 and both the link and count registers read 0.
- R2: A branch presented with `br_valid` high in one cycle produces `res_valid` high in exactly the next cycle, with `res_taken` and `res_next` for that branch. `res_valid` is low in every cycle that does not follow a branch.
- R3: `cond_mode` selects the condition test: 0 or 3 = the bit is not examined, 1 = the bit must be 1, 2 = the bit must be 0. The tested bit is `cr_value[bit_sel]`, where index 0 is the least significant bit.
- R4: `cnt_mode` selects the count test: 0 = no decrement and no test, 1 = decrement and require the new value to be non-zero, 2 = decrement and require the new value to be zero, 3 = decrement without a test. The decrement wraps from 0 to 0xFFFFFFFF.
- R5: A branch is taken only when the condition test and the count test both pass.
- R6: `tgt_src` selects the target: 0 = `cur_addr` plus the sign-extended 24-bit byte displacement, 1 = the sign-extended displacement as an absolute address, 2 = the link register, 3 = the count register. Bits 1:0 of every target are forced to 0.
- R7: A count-register target uses the count value from before that branch's decrement. A link-register target uses the link value from before that branch's link write.
- R8: A branch that is not taken yields `res_next = cur_addr + 4`.
- R9: When `link_en` is set, the link register receives `cur_addr + 4`, whether or not the branch is taken.
- R10: `wr_en` loads `wr_data` into the link register (`wr_sel` = 0) or into the count register (`wr_sel` = 1). When a branch updates the same register in the same cycle, the branch's value wins. Without a branch update or a write, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch is presented this cycle |
| cur_addr | input | 32 | Address of the branch instruction |
| cr_value | input | 32 | Condition register value |
| bit_sel | input | 5 | Index of the condition bit to test |
| cond_mode | input | 2 | Condition bit test option |
| cnt_mode | input | 2 | Count decrement and test option |
| link_en | input | 1 | Save the return address in the link register |
| tgt_src | input | 2 | Target address source |
| disp | input | 24 | Signed byte displacement |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 link, 1 count |
| wr_data | input | 32 | Register write data |
| res_valid | output | 1 | Branch result valid |
| res_taken | output | 1 | Branch was taken |
| res_next | output | 32 | Next fetch address |
| lr_out | output | 32 | Link register |
| ctr_out | output | 32 | Count register |

## Verification
The hardest states to reach from the ports are the ones where one register feeds the target and is also rewritten by the same branch. Examples are a count-register target combined with a decrement, and a link-register target combined with the link bit. The count can also reach zero and then wrap. The stimulus first loads small counts through the write port. It then issues loop branches back to back until the count is exhausted, and decrements once more so the value wraps. A reference model in the bench tracks both registers across every step, so the pre-update values are known exactly. Other cases put a write and a branch update on the same register in one cycle.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef enum logic [1:0] {
    CBIT_ANY  = 2'd0,
    CBIT_ONE  = 2'd1,
    CBIT_ZERO = 2'd2,
    CBIT_ANYB = 2'd3
  } cbit_mode_e;

  typedef enum logic [1:0] {
    CNT_KEEP  = 2'd0,
    CNT_NZ    = 2'd1,
    CNT_Z     = 2'd2,
    CNT_DEC   = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    TGT_REL = 2'd0,
    TGT_ABS = 2'd1,
    TGT_LNK = 2'd2,
    TGT_CNT = 2'd3
  } tgt_src_e;
endpackage

// File: rtl/brx_cond.sv
module brx_cond
  import brx_pkg::*;
#(
  parameter int RW  = 32,
  parameter int CRW = 32,
  localparam int CIW = $clog2(CRW)
) (
  input  logic [CRW-1:0] cr_value,
  input  logic [CIW-1:0] bit_sel,
  input  logic [1:0]     cond_mode,
  input  logic [1:0]     cnt_mode,
  input  logic [RW-1:0]  ctr_cur,
  output logic           taken,
  output logic           dec_en,
  output logic [RW-1:0]  ctr_dec
);
  cbit_mode_e cm;
  cnt_mode_e  km;
  logic       bit_v;
  logic       bit_ok;
  logic       cnt_ok;

  always_comb begin
    cm      = cbit_mode_e'(cond_mode);
    km      = cnt_mode_e'(cnt_mode);
    bit_v   = cr_value[bit_sel];
    ctr_dec = ctr_cur - {{(RW-1){1'b0}}, 1'b1};
    dec_en  = (km != CNT_KEEP);
    unique case (cm)
      CBIT_ONE:  bit_ok = bit_v;
      CBIT_ZERO: bit_ok = ~bit_v;
      default:   bit_ok = 1'b1;
    endcase
    unique case (km)
      CNT_NZ:  cnt_ok = (ctr_dec != '0);
      CNT_Z:   cnt_ok = (ctr_dec == '0);
      default: cnt_ok = 1'b1;
    endcase
    taken = bit_ok & cnt_ok;
  end
endmodule

// File: rtl/brx_target.sv
module brx_target
  import brx_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 24
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] disp,
  input  logic [1:0]    tgt_src,
  input  logic [AW-1:0] lr_cur,
  input  logic [AW-1:0] ctr_cur,
  input  logic          taken,
  output logic [AW-1:0] seq_addr,
  output logic [AW-1:0] next_addr
);
  logic [AW-1:0] disp_x;
  logic [AW-1:0] tgt_raw;

  generate
    if (AW > DW) begin : g_sext
      assign disp_x = {{(AW-DW){disp[DW-1]}}, disp};
    end else begin : g_trunc
      assign disp_x = disp[AW-1:0];
    end
  endgenerate

  always_comb begin
    seq_addr = cur_addr + AW'(4);
    unique case (tgt_src_e'(tgt_src))
      TGT_REL: tgt_raw = cur_addr + disp_x;
      TGT_ABS: tgt_raw = disp_x;
      TGT_LNK: tgt_raw = lr_cur;
      default: tgt_raw = ctr_cur;
    endcase
    next_addr = taken ? {tgt_raw[AW-1:2], 2'b00} : seq_addr;
  end
endmodule

// File: rtl/brx_regs.sv
module brx_regs #(
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lr_we,
  input  logic [RW-1:0] lr_d,
  input  logic          ctr_we,
  input  logic [RW-1:0] ctr_d,
  output logic [RW-1:0] lr_q,
  output logic [RW-1:0] ctr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q  <= '0;
      ctr_q <= '0;
    end else begin
      if (lr_we)  lr_q  <= lr_d;
      if (ctr_we) ctr_q <= ctr_d;
    end
  end
endmodule

// File: rtl/brx_resolver.sv
module brx_resolver
  import brx_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 24,
  parameter int CRW = 32,
  localparam int CIW = $clog2(CRW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           br_valid,
  input  logic [AW-1:0]  cur_addr,
  input  logic [CRW-1:0] cr_value,
  input  logic [CIW-1:0] bit_sel,
  input  logic [1:0]     cond_mode,
  input  logic [1:0]     cnt_mode,
  input  logic           link_en,
  input  logic [1:0]     tgt_src,
  input  logic [DW-1:0]  disp,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [AW-1:0]  wr_data,
  output logic           res_valid,
  output logic           res_taken,
  output logic [AW-1:0]  res_next,
  output logic [AW-1:0]  lr_out,
  output logic [AW-1:0]  ctr_out
);
  logic          taken_c;
  logic          dec_en_c;
  logic [AW-1:0] ctr_dec_c;
  logic [AW-1:0] seq_c;
  logic [AW-1:0] next_c;
  logic          lr_we, ctr_we;
  logic [AW-1:0] lr_d, ctr_d;
  logic          link_upd, cnt_upd;

  logic          valid_q;
  logic          taken_q;
  logic [AW-1:0] next_q;

  brx_cond #(.RW(AW), .CRW(CRW)) u_cond (
    .cr_value  (cr_value),
    .bit_sel   (bit_sel),
    .cond_mode (cond_mode),
    .cnt_mode  (cnt_mode),
    .ctr_cur   (ctr_out),
    .taken     (taken_c),
    .dec_en    (dec_en_c),
    .ctr_dec   (ctr_dec_c)
  );

  brx_target #(.AW(AW), .DW(DW)) u_tgt (
    .cur_addr  (cur_addr),
    .disp      (disp),
    .tgt_src   (tgt_src),
    .lr_cur    (lr_out),
    .ctr_cur   (ctr_out),
    .taken     (taken_c),
    .seq_addr  (seq_c),
    .next_addr (next_c)
  );

  always_comb begin
    link_upd = br_valid & link_en;
    cnt_upd  = br_valid & dec_en_c;
    lr_we    = link_upd | (wr_en & ~wr_sel);
    ctr_we   = cnt_upd  | (wr_en &  wr_sel);
    lr_d     = link_upd ? seq_c     : wr_data;
    ctr_d    = cnt_upd  ? ctr_dec_c : wr_data;
  end

  brx_regs #(.RW(AW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .lr_we  (lr_we),
    .lr_d   (lr_d),
    .ctr_we (ctr_we),
    .ctr_d  (ctr_d),
    .lr_q   (lr_out),
    .ctr_q  (ctr_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      taken_q <= 1'b0;
      next_q  <= '0;
    end else begin
      valid_q <= br_valid;
      if (br_valid) begin
        taken_q <= taken_c;
        next_q  <= next_c;
      end
    end
  end

  assign res_valid = valid_q;
  assign res_taken = taken_q;
  assign res_next  = next_q;
endmodule

// File: rtl/brx_resolver_chk.sv
module brx_resolver_chk #(
  parameter int AW  = 32,
  parameter int DW  = 24,
  parameter int CRW = 32,
  localparam int CIW = $clog2(CRW)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           br_valid,
  input logic [AW-1:0]  cur_addr,
  input logic [1:0]     cnt_mode,
  input logic           link_en,
  input logic           wr_en,
  input logic           res_valid,
  input logic           res_taken,
  input logic [AW-1:0]  res_next,
  input logic [AW-1:0]  lr_out,
  input logic [AW-1:0]  ctr_out
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> res_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> !res_valid);
  assert_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_taken |-> res_next[1:0] == 2'b00);
  assert_fallthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> (res_taken || res_next == $past(cur_addr) + AW'(4)));
  assert_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && link_en |=> lr_out == $past(cur_addr) + AW'(4));
  assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && cnt_mode != 2'd0 |=> ctr_out == $past(ctr_out) - AW'(1));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid && !wr_en |=> $stable(lr_out) && $stable(ctr_out));
endmodule

bind brx_resolver brx_resolver_chk #(.AW(AW), .DW(DW), .CRW(CRW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .br_valid  (br_valid),
  .cur_addr  (cur_addr),
  .cnt_mode  (cnt_mode),
  .link_en   (link_en),
  .wr_en     (wr_en),
  .res_valid (res_valid),
  .res_taken (res_taken),
  .res_next  (res_next),
  .lr_out    (lr_out),
  .ctr_out   (ctr_out)
);

// File: tb/brx_resolver_tb.sv
module brx_resolver_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        br_valid;
  logic [31:0] cur_addr, cr_value;
  logic [4:0]  bit_sel;
  logic [1:0]  cond_mode, cnt_mode, tgt_src;
  logic        link_en;
  logic [23:0] disp;
  logic        wr_en, wr_sel;
  logic [31:0] wr_data;
  logic        res_valid, res_taken;
  logic [31:0] res_next, lr_out, ctr_out;

  brx_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .cur_addr(cur_addr),
    .cr_value(cr_value), .bit_sel(bit_sel), .cond_mode(cond_mode),
    .cnt_mode(cnt_mode), .link_en(link_en), .tgt_src(tgt_src), .disp(disp),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .res_valid(res_valid), .res_taken(res_taken), .res_next(res_next),
    .lr_out(lr_out), .ctr_out(ctr_out)
  );

  typedef struct {
    logic        tk;
    logic [31:0] nxt;
    logic [31:0] lr;
    logic [31:0] ctr;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          total = 0;
  int          bad = 0;
  bit          done = 0;
  logic [31:0] m_lr, m_ctr;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check32(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: computes expectation from the requirements, queues it, drives pins
  task automatic drive(input bit bv, input logic [31:0] ca, input logic [31:0] cr,
                       input logic [4:0] bs, input logic [1:0] cm, input logic [1:0] km,
                       input bit lk, input logic [1:0] ts, input logic [23:0] dp,
                       input bit we, input bit ws, input logic [31:0] wd,
                       input string tag);
    logic        cond_ok, cnt_ok, tk;
    logic [31:0] nc, seq, sx, tgt, nxt, nlr, nctr;
    exp_t        e;
    cond_ok = (cm == 2'd1) ? cr[bs] : (cm == 2'd2) ? !cr[bs] : 1'b1;
    nc      = m_ctr - 32'd1;
    cnt_ok  = (km == 2'd1) ? (nc != 0) : (km == 2'd2) ? (nc == 0) : 1'b1;
    tk      = cond_ok && cnt_ok;
    seq     = ca + 32'd4;
    sx      = {{8{dp[23]}}, dp};
    case (ts)
      2'd0:    tgt = ca + sx;
      2'd1:    tgt = sx;
      2'd2:    tgt = m_lr;
      default: tgt = m_ctr;
    endcase
    tgt[1:0] = 2'b00;
    nxt  = tk ? tgt : seq;
    nlr  = m_lr;
    nctr = m_ctr;
    if (we && !ws) nlr = wd;
    if (we && ws)  nctr = wd;
    if (bv && lk) nlr = seq;
    if (bv && km != 2'd0) nctr = nc;
    if (bv) begin
      e.tk = tk; e.nxt = nxt; e.lr = nlr; e.ctr = nctr; e.tag = tag;
      sb.push_back(e);
    end
    m_lr = nlr; m_ctr = nctr;
    @(posedge clk); #1;
    br_valid = bv; cur_addr = ca; cr_value = cr; bit_sel = bs;
    cond_mode = cm; cnt_mode = km; link_en = lk; tgt_src = ts; disp = dp;
    wr_en = we; wr_sel = ws; wr_data = wd;
  endtask

  task automatic idle();
    drive(0, 32'h0, 32'h0, 5'd0, 2'd0, 2'd0, 0, 2'd0, 24'h0, 0, 0, 32'h0, "idle");
  endtask

  task automatic br(input logic [31:0] ca, input logic [31:0] cr, input logic [4:0] bs,
                    input logic [1:0] cm, input logic [1:0] km, input bit lk,
                    input logic [1:0] ts, input logic [23:0] dp, input string tag);
    drive(1, ca, cr, bs, cm, km, lk, ts, dp, 0, 0, 32'h0, tag);
  endtask

  task automatic wr(input bit ws, input logic [31:0] wd, input string tag);
    drive(0, 32'h0, 32'h0, 5'd0, 2'd0, 2'd0, 0, 2'd0, 24'h0, 1, ws, wd, tag);
  endtask

  // monitor: pops and compares, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done && res_valid) begin
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 res_valid actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check32(e.tag, "taken", {31'b0, res_taken}, {31'b0, e.tk});
        check32(e.tag, "next", res_next, e.nxt);
        check32(e.tag, "lr", lr_out, e.lr);
        check32(e.tag, "ctr", ctr_out, e.ctr);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; br_valid = 0; cur_addr = 0; cr_value = 0; bit_sel = 0;
    cond_mode = 0; cnt_mode = 0; link_en = 0; tgt_src = 0; disp = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0;
    m_lr = 0; m_ctr = 0;
    repeat (3) @(posedge clk);
    #1;
    check32("R1", "res_valid in reset", {31'b0, res_valid}, 32'h0);
    check32("R1", "lr in reset", lr_out, 32'h0);
    check32("R1", "ctr in reset", ctr_out, 32'h0);
    rst_n = 1;
    repeat (2) @(posedge clk);
    #1;
    check32("R1", "res_valid after reset", {31'b0, res_valid}, 32'h0);

    // R6 unconditional targets: relative +/-, absolute, low bits cleared
    br(32'h0000_1000, 32'h0, 5'd0, 2'd0, 2'd0, 0, 2'd0, 24'h000103, "R6");
    br(32'h0000_1000, 32'h0, 5'd0, 2'd0, 2'd0, 0, 2'd0, 24'hFFFF00, "R6");
    br(32'h0000_2000, 32'h0, 5'd0, 2'd3, 2'd0, 0, 2'd1, 24'h80_0002, "R6");
    // R3 condition bit tests, bit 0 and bit 31, both polarities
    br(32'h100, 32'h0000_0001, 5'd0,  2'd1, 2'd0, 0, 2'd0, 24'h40, "R3");
    br(32'h100, 32'h0000_0001, 5'd0,  2'd2, 2'd0, 0, 2'd0, 24'h40, "R3");
    br(32'h100, 32'h8000_0000, 5'd31, 2'd1, 2'd0, 0, 2'd0, 24'h40, "R3");
    br(32'h100, 32'h7FFF_FFFF, 5'd31, 2'd2, 2'd0, 0, 2'd0, 24'h40, "R3");
    br(32'h100, 32'hFFFF_FFFE, 5'd0,  2'd1, 2'd0, 0, 2'd0, 24'h40, "R8");
    idle();

    // R4 count loop: load 3, branch-while-nonzero until exhausted
    wr(1, 32'd3, "R10");
    br(32'h400, 32'h0, 5'd0, 2'd0, 2'd1, 0, 2'd0, 24'hFFFFF0, "R4");
    br(32'h400, 32'h0, 5'd0, 2'd0, 2'd1, 0, 2'd0, 24'hFFFFF0, "R4");
    br(32'h400, 32'h0, 5'd0, 2'd0, 2'd1, 0, 2'd0, 24'hFFFFF0, "R4");
    // count now 0: decrement wraps to all ones, nonzero test passes
    br(32'h400, 32'h0, 5'd0, 2'd0, 2'd1, 0, 2'd0, 24'h20, "R4");
    // zero test and decrement-only mode
    wr(1, 32'd1, "R10");
    br(32'h500, 32'h0, 5'd0, 2'd0, 2'd2, 0, 2'd0, 24'h10, "R4");
    br(32'h500, 32'h0, 5'd0, 2'd0, 2'd3, 0, 2'd0, 24'h10, "R4");
    idle();

    // R5 both tests required
    wr(1, 32'd5, "R10");
    br(32'h600, 32'h0, 5'd4, 2'd1, 2'd1, 0, 2'd0, 24'h80, "R5");
    br(32'h600, 32'h10, 5'd4, 2'd1, 2'd2, 0, 2'd0, 24'h80, "R5");
    br(32'h600, 32'h10, 5'd4, 2'd1, 2'd1, 0, 2'd0, 24'h80, "R5");
    idle();

    // R7 register targets use pre-update values
    wr(0, 32'hDEAD_BEEF, "R10");
    br(32'h0000_0700, 32'h0, 5'd0, 2'd0, 2'd0, 1, 2'd2, 24'h0, "R7");
    wr(1, 32'h1234_5679, "R10");
    br(32'h0000_0800, 32'h0, 5'd0, 2'd0, 2'd3, 0, 2'd3, 24'h0, "R7");
    // R9 link written although not taken
    br(32'h0000_0900, 32'h0, 5'd2, 2'd1, 2'd0, 1, 2'd0, 24'h40, "R9");
    // R10 branch beats a write on the same register; other register written
    drive(1, 32'h0000_0A00, 32'h0, 5'd0, 2'd0, 2'd0, 1, 2'd0, 24'h8,
          1, 0, 32'hAAAA_5555, "R10");
    drive(1, 32'h0000_0B00, 32'h0, 5'd0, 2'd0, 2'd3, 0, 2'd0, 24'h8,
          1, 1, 32'h7777_0000, "R10");
    drive(1, 32'h0000_0C00, 32'h0, 5'd0, 2'd0, 2'd0, 0, 2'd2, 24'h8,
          1, 1, 32'h0BAD_F00D, "R10");
    drive(1, 32'h0000_0D00, 32'h0, 5'd0, 2'd0, 2'd0, 0, 2'd3, 24'h8,
          0, 0, 32'h0, "R10");
    idle();
    repeat (4) idle();

    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R2 pending results actual=%0d expected=0", sb.size());
    end
    finish_run();
  end
endmodule